// File: doc/BRIEF.md
# Way-Predicted Two-Way Cache Lookup

This block is the tag lookup path of a small two-way set-associative cache. Each set keeps one prediction bit that names the way to probe first. When a request is accepted, the index field selects a set and only the predicted way's tag is compared. If that tag matches, the addressed word comes back one cycle after acceptance. If it does not match, the block stalls the request port for one cycle and compares the other way. That second probe ends in either a slow hit or a miss. A slow hit also retrains the set's prediction bit to the way that actually held the line.

Lines are loaded through a fill port. In one cycle it writes a tag, a whole block and a valid bit into a chosen way of a chosen set, and it points that set's prediction at the filled way. Refill sequencing, store handling and victim choice belong to the surrounding cache controller. Only one lookup is in flight at a time. During the second probe, `req_ready_o` is low.

Top module: `wp_lookup`

## Requirements
- R1: With the default parameters, the request address splits into bits [3:0] = word offset within a 16-word block, bits [7:4] = set index (16 sets), and bits [31:8] = tag. All 24 tag bits take part in the compare, and the returned 32-bit word is the one the offset selects within the matching block.
- R2: After reset, every line in both ways is invalid, every prediction bit points at way 0, `req_ready_o` is 1 and no response is presented. A lookup then reports a miss.
- R3: A request is accepted on a rising edge where `req_valid_i` and `req_ready_o` are both 1. If the predicted way holds a valid matching tag, the response appears in the next cycle with hit=1, slow_hit=0 and the word. `req_ready_o` stays 1, so back-to-back fast hits complete one per cycle.
- R4: If the predicted way does not match, then in the cycle after acceptance `req_ready_o` is 0 and no response is presented. The response appears in the cycle after that, and `req_ready_o` returns to 1 in the same cycle.
- R5: If the other way holds a valid matching tag, the delayed response has hit=1 and slow_hit=1 and carries the word. That set's prediction bit is set to the matching way, so the next lookup of the same line is a fast hit.
- R6: If neither way holds a valid matching tag, the delayed response has hit=0, slow_hit=0 and data 0. The prediction bit is left unchanged.
- R7: A fill writes the tag, block and valid bit of the given way and set. From the next accepted request on, it is visible. The set's prediction bit then points at the filled way, and the other way of that set is left untouched.
- R8: While `rsp_valid_o` is 0, `rsp_hit_o`, `rsp_slow_hit_o` and `rsp_data_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request present |
| req_addr_i | input | ADDR_W | Word address of the lookup |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| rsp_valid_o | output | 1 | Response present |
| rsp_hit_o | output | 1 | Line found in either way |
| rsp_slow_hit_o | output | 1 | Line found only on the second probe |
| rsp_data_o | output | WORD_W | Addressed word on a hit, 0 otherwise |
| fill_valid_i | input | 1 | Write a line this cycle |
| fill_way_i | input | 1 | Way to write |
| fill_idx_i | input | IDX_W | Set to write |
| fill_tag_i | input | TAG_W | Tag stored with the line |
| fill_data_i | input | WORD_W*2^OFFS_W | Whole block, word 0 in the low bits |

## Verification
A corrupted prediction bit does not change the data that comes back. It does change the timing: a line that should hit fast returns one cycle late with slow_hit set, and a retrain that was missed shows up as a second slow hit on the very next lookup of that line. A wrong valid bit or tag shows at once, as a false miss or a false hit on the first lookup of that set. A wrong data word shows directly on `rsp_data_o`. Because of this, the bench checks the exact cycle of each response as well as its payload, across every set and every offset.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int unsigned NUM_WAYS = 2;

  typedef enum logic {
    ST_PROBE_FIRST = 1'b0,
    ST_PROBE_ALT   = 1'b1
  } probe_state_e;
endpackage

// File: rtl/wp_tag_way.sv
module wp_tag_way #(
  parameter int unsigned TAG_W = 24,
  parameter int unsigned IDX_W = 4,
  localparam int unsigned SETS = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fill_en_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic [IDX_W-1:0] look_idx_i,
  input  logic [TAG_W-1:0] look_tag_i,
  output logic             match_o
);
  logic [SETS-1:0]  valid_q;
  logic [TAG_W-1:0] tag_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        valid_q <= '0;
    else if (fill_en_i) valid_q[fill_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (fill_en_i) tag_q[fill_idx_i] <= fill_tag_i;
  end

  assign match_o = valid_q[look_idx_i] && (tag_q[look_idx_i] == look_tag_i);
endmodule

// File: rtl/wp_data_way.sv
module wp_data_way #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned OFFS_W = 4,
  parameter int unsigned IDX_W  = 4,
  localparam int unsigned WPB   = 1 << OFFS_W,
  localparam int unsigned SETS  = 1 << IDX_W,
  localparam int unsigned BLK_W = WORD_W * WPB
) (
  input  logic              clk_i,
  input  logic              fill_en_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [BLK_W-1:0]  fill_blk_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [OFFS_W-1:0] rd_off_i,
  output logic [WORD_W-1:0] rd_word_o
);
  logic [WORD_W-1:0] mem_q [SETS*WPB];

  always_ff @(posedge clk_i) begin
    if (fill_en_i) begin
      for (int w = 0; w < int'(WPB); w++) begin
        mem_q[{fill_idx_i, OFFS_W'(w)}] <= fill_blk_i[w*WORD_W +: WORD_W];
      end
    end
  end

  assign rd_word_o = mem_q[{rd_idx_i, rd_off_i}];
endmodule

// File: rtl/wp_pred_table.sv
module wp_pred_table #(
  parameter int unsigned IDX_W = 4,
  localparam int unsigned SETS = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_way_o,
  input  logic             fill_en_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic             fill_way_i,
  input  logic             trn_en_i,
  input  logic [IDX_W-1:0] trn_idx_i,
  input  logic             trn_way_i
);
  logic [SETS-1:0] pred_q;

  // fill wins over retrain on the same set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_q <= '0;
    end else begin
      if (trn_en_i)  pred_q[trn_idx_i]  <= trn_way_i;
      if (fill_en_i) pred_q[fill_idx_i] <= fill_way_i;
    end
  end

  assign rd_way_o = pred_q[rd_idx_i];
endmodule

// File: rtl/wp_lookup.sv
module wp_lookup #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned OFFS_W = 4,
  parameter int unsigned IDX_W  = 4,
  localparam int unsigned WPB   = 1 << OFFS_W,
  localparam int unsigned TAG_W = ADDR_W - OFFS_W - IDX_W,
  localparam int unsigned BLK_W = WORD_W * WPB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_slow_hit_o,
  output logic [WORD_W-1:0] rsp_data_o,
  input  logic              fill_valid_i,
  input  logic              fill_way_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [BLK_W-1:0]  fill_data_i
);
  import wp_pkg::*;

  probe_state_e      state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              alt_way_q;

  logic [ADDR_W-1:0] look_addr;
  logic [OFFS_W-1:0] look_off;
  logic [IDX_W-1:0]  look_idx;
  logic [TAG_W-1:0]  look_tag;
  logic              pred_way, probe_way, probe_hit, accept, in_alt, train_en;
  logic [NUM_WAYS-1:0] way_match;
  logic [WORD_W-1:0]   way_word [NUM_WAYS];

  logic              rsp_valid_q, rsp_hit_q, rsp_slow_q;
  logic [WORD_W-1:0] rsp_data_q;

  assign in_alt    = (state_q == ST_PROBE_ALT);
  assign look_addr = in_alt ? addr_q : req_addr_i;
  assign look_off  = look_addr[OFFS_W-1:0];
  assign look_idx  = look_addr[OFFS_W +: IDX_W];
  assign look_tag  = look_addr[ADDR_W-1 -: TAG_W];

  wp_pred_table #(.IDX_W(IDX_W)) u_pred (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (look_idx),
    .rd_way_o   (pred_way),
    .fill_en_i  (fill_valid_i),
    .fill_idx_i (fill_idx_i),
    .fill_way_i (fill_way_i),
    .trn_en_i   (train_en),
    .trn_idx_i  (look_idx),
    .trn_way_i  (alt_way_q)
  );

  for (genvar g = 0; g < int'(NUM_WAYS); g++) begin : g_way
    logic fill_here;
    assign fill_here = fill_valid_i && (fill_way_i == 1'(g));

    wp_tag_way #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tag (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .fill_en_i  (fill_here),
      .fill_idx_i (fill_idx_i),
      .fill_tag_i (fill_tag_i),
      .look_idx_i (look_idx),
      .look_tag_i (look_tag),
      .match_o    (way_match[g])
    );

    wp_data_way #(.WORD_W(WORD_W), .OFFS_W(OFFS_W), .IDX_W(IDX_W)) u_data (
      .clk_i      (clk_i),
      .fill_en_i  (fill_here),
      .fill_idx_i (fill_idx_i),
      .fill_blk_i (fill_data_i),
      .rd_idx_i   (look_idx),
      .rd_off_i   (look_off),
      .rd_word_o  (way_word[g])
    );
  end

  assign probe_way = in_alt ? alt_way_q : pred_way;
  assign probe_hit = way_match[probe_way];
  assign accept    = req_valid_i && !in_alt;
  assign train_en  = in_alt && probe_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_PROBE_FIRST;
      addr_q    <= '0;
      alt_way_q <= 1'b0;
    end else if (in_alt) begin
      state_q <= ST_PROBE_FIRST;
    end else if (accept && !probe_hit) begin
      state_q   <= ST_PROBE_ALT;
      addr_q    <= req_addr_i;
      alt_way_q <= ~pred_way;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_slow_q  <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= in_alt || (accept && probe_hit);
      rsp_hit_q   <= (in_alt || accept) && probe_hit;
      rsp_slow_q  <= in_alt && probe_hit;
      rsp_data_q  <= ((in_alt || accept) && probe_hit) ? way_word[probe_way] : '0;
    end
  end

  assign req_ready_o    = !in_alt;
  assign rsp_valid_o    = rsp_valid_q;
  assign rsp_hit_o      = rsp_hit_q;
  assign rsp_slow_hit_o = rsp_slow_q;
  assign rsp_data_o     = rsp_data_q;
endmodule

// File: rtl/wp_lookup_chk.sv
module wp_lookup_chk #(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_hit_o,
  input logic              rsp_slow_hit_o,
  input logic [WORD_W-1:0] rsp_data_o
);
  // R3
  accept_fast_or_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (rsp_valid_o || !req_ready_o));

  // R3
  no_rsp_without_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(req_ready_o) && !$past(req_valid_i)) |-> !rsp_valid_o);

  // R4
  stall_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> req_ready_o);

  // R4
  stall_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |-> !rsp_valid_o);

  // R4
  stall_end_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_ready_o) |-> rsp_valid_o);

  // R5
  slow_is_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_slow_hit_o |-> (rsp_hit_o && $rose(req_ready_o)));

  // R6
  miss_zero_late_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_data_o == '0 && $rose(req_ready_o)));

  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!rsp_hit_o && !rsp_slow_hit_o && rsp_data_o == '0));
endmodule

bind wp_lookup wp_lookup_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/wp_lookup_tb_top.sv
module wp_lookup_tb_top;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned OFFS_W = 4;
  localparam int unsigned IDX_W  = 4;
  localparam int unsigned WPB    = 1 << OFFS_W;
  localparam int unsigned SETS   = 1 << IDX_W;
  localparam int unsigned TAG_W  = ADDR_W - OFFS_W - IDX_W;
  localparam int unsigned BLK_W  = WORD_W * WPB;

  localparam logic [TAG_W-1:0] TAG_A = 24'h800123;
  localparam logic [TAG_W-1:0] TAG_B = 24'h000123; // differs from A only in MSB
  localparam logic [TAG_W-1:0] TAG_C = 24'h3A5F00;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic              req_ready_o, rsp_valid_o, rsp_hit_o, rsp_slow_hit_o;
  logic [WORD_W-1:0] rsp_data_o;
  logic              fill_valid_i = 1'b0;
  logic              fill_way_i = 1'b0;
  logic [IDX_W-1:0]  fill_idx_i = '0;
  logic [TAG_W-1:0]  fill_tag_i = '0;
  logic [BLK_W-1:0]  fill_data_i = '0;

  always #10 clk_i = ~clk_i;

  wp_lookup #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .OFFS_W(OFFS_W), .IDX_W(IDX_W)) dut_i (.*);

  int unsigned checks = 0;
  int unsigned errors = 0;
  bit          done = 1'b0;

  logic             m_val  [SETS][2];
  logic [TAG_W-1:0] m_tag  [SETS][2];
  logic             m_pred [SETS];

  function automatic logic [WORD_W-1:0] pat(logic [TAG_W-1:0] tg, logic [IDX_W-1:0] ix,
                                            logic [OFFS_W-1:0] off);
    return {tg[11:0] ^ tg[23:12], ix, off, tg[7:0] ^ 8'h5A, 4'h3};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic fill(input logic way, input logic [IDX_W-1:0] ix, input logic [TAG_W-1:0] tg);
    fill_valid_i = 1'b1;
    fill_way_i   = way;
    fill_idx_i   = ix;
    fill_tag_i   = tg;
    for (int w = 0; w < int'(WPB); w++) fill_data_i[w*WORD_W +: WORD_W] = pat(tg, ix, OFFS_W'(w));
    @(posedge clk_i);
    @(negedge clk_i);
    fill_valid_i = 1'b0;
    m_val[ix][way] = 1'b1;
    m_tag[ix][way] = tg;
    m_pred[ix]     = way;
  endtask

  // expected response packed as {valid, hit, slow, data}
  task automatic lookup(input logic [TAG_W-1:0] tg, input logic [IDX_W-1:0] ix,
                        input logic [OFFS_W-1:0] off, input string rq);
    logic pw;
    logic f_hit, s_hit;
    logic [34:0] act, exp;
    pw    = m_pred[ix];
    f_hit = m_val[ix][pw] && m_tag[ix][pw] == tg;
    s_hit = m_val[ix][~pw] && m_tag[ix][~pw] == tg;
    req_valid_i = 1'b1;
    req_addr_i  = {tg, ix, off};
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (f_hit) begin
      act = {rsp_valid_o, rsp_hit_o, rsp_slow_hit_o, rsp_data_o};
      exp = {3'b110, pat(tg, ix, off)};
      chk(act == exp && req_ready_o, {rq, " R3 fast hit"}, 64'(act), 64'(exp));
    end else begin
      chk(!rsp_valid_o && !req_ready_o, {rq, " R4 stall cycle"},
          64'({rsp_valid_o, req_ready_o}), 64'h0);
      @(negedge clk_i);
      act = {rsp_valid_o, rsp_hit_o, rsp_slow_hit_o, rsp_data_o};
      if (s_hit) begin
        exp = {3'b111, pat(tg, ix, off)};
        chk(act == exp && req_ready_o, {rq, " R5 slow hit"}, 64'(act), 64'(exp));
        m_pred[ix] = ~pw;
      end else begin
        exp = {3'b100, 32'h0};
        chk(act == exp && req_ready_o, {rq, " R6 miss"}, 64'(act), 64'(exp));
      end
    end
  endtask

  initial begin
    for (int s = 0; s < int'(SETS); s++) begin
      m_val[s][0] = 1'b0; m_val[s][1] = 1'b0;
      m_tag[s][0] = '0;   m_tag[s][1] = '0;
      m_pred[s]   = 1'b0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R2 reset state
    chk(req_ready_o && !rsp_valid_o && !rsp_hit_o && !rsp_slow_hit_o && rsp_data_o == '0,
        "R2 reset outputs", 64'({req_ready_o, rsp_valid_o, rsp_hit_o, rsp_slow_hit_o, rsp_data_o}),
        64'(36'h800000000));
    // R2: all lines invalid after reset
    for (int s = 0; s < int'(SETS); s++) lookup(TAG_A, IDX_W'(s), 4'h0, "R2 empty");
    // R8: quiet while idle
    @(negedge clk_i);
    chk(!rsp_valid_o && !rsp_hit_o && !rsp_slow_hit_o && rsp_data_o == '0, "R8 idle outputs",
        64'({rsp_valid_o, rsp_hit_o, rsp_slow_hit_o, rsp_data_o}), 64'h0);
    // R7, R1: fill way 0, sweep every set and offset
    for (int s = 0; s < int'(SETS); s++) fill(1'b0, IDX_W'(s), TAG_A);
    for (int s = 0; s < int'(SETS); s++)
      for (int o = 0; o < int'(WPB); o++) lookup(TAG_A, IDX_W'(s), OFFS_W'(o), "R1 R7 sweep");
    // R1: tag differing only in MSB must miss
    for (int s = 0; s < int'(SETS); s++) lookup(TAG_B, IDX_W'(s), 4'h7, "R1 tag msb");
    // R7: fill way 1 moves prediction; R5 retrain in both directions
    for (int s = 0; s < int'(SETS); s++) fill(1'b1, IDX_W'(s), TAG_B);
    for (int s = 0; s < int'(SETS); s++) begin
      lookup(TAG_B, IDX_W'(s), OFFS_W'(s), "R7 pred to fill way");
      lookup(TAG_A, IDX_W'(s), OFFS_W'(15 - s), "R5 retrain to way0");
      lookup(TAG_A, IDX_W'(s), OFFS_W'(s), "R5 after retrain");
      lookup(TAG_B, IDX_W'(s), 4'h2, "R5 retrain to way1");
      lookup(TAG_C, IDX_W'(s), 4'h9, "R6 miss both ways");
      lookup(TAG_B, IDX_W'(s), 4'hE, "R6 pred kept");
    end
    // R3: back-to-back fast hits, one per cycle
    req_valid_i = 1'b1;
    req_addr_i  = {TAG_B, 4'h5, 4'h0};
    for (int o = 0; o < int'(WPB); o++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      chk({rsp_valid_o, rsp_hit_o, rsp_slow_hit_o, rsp_data_o} == {3'b110, pat(TAG_B, 4'h5, OFFS_W'(o))}
          && req_ready_o, "R3 back-to-back",
          64'({req_ready_o, rsp_valid_o, rsp_hit_o, rsp_slow_hit_o, rsp_data_o}),
          64'({4'b1110, pat(TAG_B, 4'h5, OFFS_W'(o))}));
      if (o == int'(WPB) - 1) req_valid_i = 1'b0;
      else req_addr_i = {TAG_B, 4'h5, OFFS_W'(o + 1)};
    end
    // R7: refill one way, other way untouched
    fill(1'b0, 4'h3, TAG_C);
    lookup(TAG_A, 4'h3, 4'h1, "R7 replaced line");
    lookup(TAG_C, 4'h3, 4'h4, "R7 new line fast");
    lookup(TAG_B, 4'h3, 4'h8, "R7 other way kept");
    lookup(TAG_A, 4'h4, 4'h1, "R7 neighbour set kept");
    @(negedge clk_i);
    chk(!rsp_valid_o && rsp_data_o == '0, "R8 idle after run",
        64'({rsp_valid_o, rsp_data_o}), 64'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule